// File: doc/BRIEF.md
# Bus Address Tenure Controller

This block sits on the master side of a split-transaction system bus. It wins and gives back the address bus for one on-chip master. The bus is arbitrated by an external arbiter. The local master posts transfer requests as single-clock pulses. The block counts them and raises a bus-request line toward the arbiter. It waits until it holds a grant and the shared address-busy line is idle. Then it opens an address tenure with a one-clock transfer-start strobe.

While the tenure is open, the block drives address-busy active. A slave acknowledge closes the tenure. The block then drives address-busy inactive for one clock, after which it stops driving the line and a pull-up holds it high. A retry from the bus closes the tenure in the same two-step way, but the transfer stays pending. The block waits one idle clock and then arbitrates again.

All bus controls are active low. Each three-state pin is modelled as a value output plus an output enable.

Top module: `addr_tenure_ctl`

## Requirements
- R1: A pulse on `xfer_req_i` makes `br_n_o` go low on the next clock. It stays low, with no gap, until the transfer-start clock of that transfer.
- R2: `ts_n_o` falls only if `bg_n_i` was sampled low at the clock edge where the tenure began. While the grant is withheld, no tenure starts.
- R3: `ts_n_o` falls only if `abb_n_i` was sampled high at that same edge. While another master holds address-busy low, no tenure starts, even with a grant.
- R4: `ts_n_o` is low for exactly one clock, the first clock of the tenure. Its timing depends on where the block starts:
  - If the block is arbitrating with the grant held and the bus free, `ts_n_o` falls on the next clock.
  - From idle, `ts_n_o` falls on the second clock after the request pulse.
- R5: From the transfer-start clock until an acknowledge or retry is sampled, `abb_oe_o` is 1 and `abb_n_o` is 0.
- R6: When `aack_n_i` is sampled low during a tenure (with `artry_n_i` high), the next clock has `abb_oe_o`=1, `abb_n_o`=1 and `done_o`=1. On the clock after that, `abb_oe_o`=0.
- R7: When `artry_n_i` is sampled low during a tenure, retry wins over any acknowledge. The sequence that follows is:
  - On the next clock, `abb_oe_o`=1, `abb_n_o`=1, `done_o`=0 and `br_n_o`=0.
  - Then one idle clock follows with `abb_oe_o`=0.
  - Then one clock of arbitration follows.
  - With the grant held and the bus free, `ts_n_o` falls on the third clock after the release clock.
  - The transfer is not lost: a later acknowledge completes it.
- R8: In the transfer-start clock, `br_n_o` is high if only that transfer is pending. It stays low if another request is already pending.
- R9: At most MAX_PEND (default 4) transfers are held. A request pulse that arrives while the count is full is dropped and never produces a `done_o` pulse.
- R10: `aack_n_i` and `artry_n_i` have no effect outside a tenure. The pins stay idle and no `done_o` pulse occurs.
- R11: While `rst_n` is low, the outputs are held at their idle values: `br_n_o`=1, `ts_n_o`=1, `abb_oe_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | One-clock pulse from the local master posting one transfer |
| br_n_o | output | 1 | Bus request to the external arbiter, active low |
| bg_n_i | input | 1 | Bus grant from the arbiter, active low |
| abb_n_i | input | 1 | Sensed level of the shared address-busy line |
| abb_n_o | output | 1 | Value driven onto address-busy |
| abb_oe_o | output | 1 | Output enable for address-busy |
| ts_n_o | output | 1 | Transfer-start strobe, active low |
| aack_n_i | input | 1 | Address acknowledge from the slave, active low |
| artry_n_i | input | 1 | Address retry, active low |
| done_o | output | 1 | One-clock pulse when a tenure is acknowledged |

## Verification
The assertions assume that the arbiter, the competing master and the slave all change their lines only between clock edges. They also assume that `abb_n_i` reflects the resolved line: the block's own drive when `abb_oe_o` is 1, and otherwise the other master or the pull-up. The bench drives every input on the falling edge and builds `abb_n_i` from exactly that resolution.

Acknowledge and retry are driven in the transfer-start clock or later, and are never sampled during the block's own release clock. The one exception is the test that drives them deliberately outside any tenure, to show they are ignored.

// File: rtl/atc_pkg.sv
package atc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_TENURE,
        ST_RELEASE,
        ST_BACKOFF
    } atc_state_e;

    typedef struct packed {
        atc_state_e st;
        logic       first;
        logic       retried;
        logic       br;
        logic       done;
    } atc_regs_t;

endpackage

// File: rtl/atc_pend_cnt.sv
module atc_pend_cnt #(
    parameter int MAX_PEND = 4,
    localparam int CW = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [CW-1:0] cnt_d_o
);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          inc;

    always_comb begin
        inc   = push_i && (cnt_q != CW'(MAX_PEND));
        cnt_d = cnt_q;
        if (inc && !pop_i)
            cnt_d = cnt_q + CW'(1);
        else if (!inc && pop_i)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_d_o = cnt_d;

endmodule

// File: rtl/atc_pin_map.sv
module atc_pin_map
    import atc_pkg::*;
(
    input  atc_state_e st_i,
    input  logic       first_i,
    output logic       ts_n_o,
    output logic       abb_n_o,
    output logic       abb_oe_o
);

    always_comb begin
        ts_n_o   = !((st_i == ST_TENURE) && first_i);
        abb_oe_o = (st_i == ST_TENURE) || (st_i == ST_RELEASE);
        abb_n_o  = (st_i != ST_TENURE);
    end

endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl
    import atc_pkg::*;
#(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    output logic br_n_o,
    input  logic bg_n_i,
    input  logic abb_n_i,
    output logic abb_n_o,
    output logic abb_oe_o,
    output logic ts_n_o,
    input  logic aack_n_i,
    input  logic artry_n_i,
    output logic done_o
);

    localparam int CW = $clog2(MAX_PEND + 1);

    atc_regs_t     r_q, r_d;
    logic          pop;
    logic [CW-1:0] cnt_d;

    // a tenure leaves the pending count only on a clean acknowledge
    assign pop = (r_q.st == ST_TENURE) && !aack_n_i && artry_n_i;

    atc_pend_cnt #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (xfer_req_i),
        .pop_i   (pop),
        .cnt_d_o (cnt_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cnt_d != '0) r_d.st = ST_ARB;
            end
            ST_ARB: begin
                if (!bg_n_i && abb_n_i) begin
                    r_d.st    = ST_TENURE;
                    r_d.first = 1'b1;
                end
            end
            ST_TENURE: begin
                r_d.first = 1'b0;
                if (!artry_n_i) begin
                    r_d.st      = ST_RELEASE;
                    r_d.retried = 1'b1;
                end else if (!aack_n_i) begin
                    r_d.st      = ST_RELEASE;
                    r_d.retried = 1'b0;
                    r_d.done    = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (r_q.retried)         r_d.st = ST_BACKOFF;
                else if (cnt_d != '0)    r_d.st = ST_ARB;
                else                     r_d.st = ST_IDLE;
                r_d.retried = 1'b0;
            end
            ST_BACKOFF: begin
                r_d.st = ST_ARB;
            end
            default: r_d.st = ST_IDLE;
        endcase

        // the in-flight transfer stops counting toward the request once started
        unique case (r_d.st)
            ST_IDLE:   r_d.br = 1'b0;
            ST_TENURE: r_d.br = (cnt_d > CW'(1));
            default:   r_d.br = (cnt_d != '0);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.first   <= 1'b0;
            r_q.retried <= 1'b0;
            r_q.br      <= 1'b0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    atc_pin_map u_pins (
        .st_i     (r_q.st),
        .first_i  (r_q.first),
        .ts_n_o   (ts_n_o),
        .abb_n_o  (abb_n_o),
        .abb_oe_o (abb_oe_o)
    );

    assign br_n_o = !r_q.br;
    assign done_o = r_q.done;

endmodule

// File: rtl/atc_chk.sv
module atc_chk (
    input logic clk,
    input logic rst_n,
    input logic br_n_o,
    input logic bg_n_i,
    input logic abb_n_i,
    input logic abb_n_o,
    input logic abb_oe_o,
    input logic ts_n_o,
    input logic aack_n_i,
    input logic artry_n_i,
    input logic done_o
);

    a_r1_req_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_n_o) |-> $past(!br_n_o));

    a_r2_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_n_o) |-> $past(!bg_n_i));

    a_r3_start_needs_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_n_o) |-> $past(abb_n_i));

    a_r4_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_n_o |=> ts_n_o);

    a_r5_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_n_o |-> (abb_oe_o && !abb_n_o));

    a_r5_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (abb_oe_o && !abb_n_o && aack_n_i && artry_n_i) |=> (abb_oe_o && !abb_n_o));

    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (abb_oe_o && !abb_n_o && !aack_n_i && artry_n_i) |=> (abb_oe_o && abb_n_o && done_o));

    a_r6_float_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (abb_oe_o && abb_n_o) |=> !abb_oe_o);

    a_r7_retry_release: assert property (@(posedge clk) disable iff (!rst_n)
        (abb_oe_o && !abb_n_o && !artry_n_i) |=> (abb_oe_o && abb_n_o && !done_o && !br_n_o));

    a_r7_retry_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (abb_oe_o && abb_n_o && !done_o) |=> (ts_n_o && !br_n_o) ##1 ts_n_o);

    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (br_n_o && ts_n_o && !abb_oe_o && !done_o));

endmodule

bind addr_tenure_ctl atc_chk u_atc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_n_o    (br_n_o),
    .bg_n_i    (bg_n_i),
    .abb_n_i   (abb_n_i),
    .abb_n_o   (abb_n_o),
    .abb_oe_o  (abb_oe_o),
    .ts_n_o    (ts_n_o),
    .aack_n_i  (aack_n_i),
    .artry_n_i (artry_n_i),
    .done_o    (done_o)
);

// File: tb/tb_addr_tenure_ctl.sv
`timescale 1ns/1ps
module tb_addr_tenure_ctl;

    localparam int MAX_PEND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_req = 1'b0;
    logic bg_n = 1'b1;
    logic comp_abb_n = 1'b1;
    logic aack_n = 1'b1;
    logic artry_n = 1'b1;
    logic br_n_o, abb_n_o, abb_oe_o, ts_n_o, done_o;
    logic abb_line;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // resolved address-busy line: own drive, else competitor, else pull-up (comp idles at 1)
    assign abb_line = abb_oe_o ? abb_n_o : comp_abb_n;

    addr_tenure_ctl #(.MAX_PEND(MAX_PEND)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_req_i (xfer_req),
        .br_n_o     (br_n_o),
        .bg_n_i     (bg_n),
        .abb_n_i    (abb_line),
        .abb_n_o    (abb_n_o),
        .abb_oe_o   (abb_oe_o),
        .ts_n_o     (ts_n_o),
        .aack_n_i   (aack_n),
        .artry_n_i  (artry_n),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    // waits on falling edges for the strobe; returns edges waited or -1
    task automatic wait_ts(output int n);
        n = -1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (!ts_n_o) begin
                n = i;
                break;
            end
        end
    endtask

    // called at the falling edge where the strobe is seen
    task automatic ack_now(input string tag);
        aack_n = 1'b0;
        @(negedge clk);
        aack_n = 1'b1;
        chk(done_o && abb_oe_o && abb_n_o, tag, {done_o, abb_oe_o, abb_n_o}, 3'b111);
        @(negedge clk);
        chk(!abb_oe_o, tag, abb_oe_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(br_n_o && ts_n_o && !abb_oe_o && !done_o, "R11 reset idle",
            {br_n_o, ts_n_o, abb_oe_o, done_o}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic(input int dly);
        int n;
        bg_n = 1'b0;
        pulse_req();
        chk(!br_n_o, "R1 request raised", br_n_o, 0);
        wait_ts(n);
        chk(n == 1, "R4 start two clocks after pulse", n, 1);
        chk(br_n_o, "R8 request dropped at start", br_n_o, 1);
        chk(abb_oe_o && !abb_n_o, "R5 busy at start", {abb_oe_o, abb_n_o}, 2'b10);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(ts_n_o, "R4 strobe one clock", ts_n_o, 1);
            chk(abb_oe_o && !abb_n_o, "R5 busy held", {abb_oe_o, abb_n_o}, 2'b10);
        end
        ack_now("R6 ack release");
    endtask

    task automatic t_busy();
        int n;
        bg_n = 1'b0;
        comp_abb_n = 1'b0;
        pulse_req();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(ts_n_o, "R3 no start while busy", ts_n_o, 1);
        end
        comp_abb_n = 1'b1;
        @(negedge clk);
        chk(!ts_n_o, "R3 start once free", ts_n_o, 0);
        ack_now("R6 ack after busy");
    endtask

    task automatic t_nogrant();
        int n;
        bg_n = 1'b1;
        pulse_req();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(ts_n_o && !br_n_o, "R2 no start without grant", {ts_n_o, br_n_o}, 2'b10);
        end
        bg_n = 1'b0;
        @(negedge clk);
        chk(!ts_n_o, "R4 start one clock after grant", ts_n_o, 0);
        ack_now("R6 ack after grant");
    endtask

    task automatic t_retry();
        int n;
        bg_n = 1'b0;
        pulse_req();
        wait_ts(n);
        chk(n > 0, "R7 first start", n, 1);
        artry_n = 1'b0;
        aack_n  = 1'b0;   // retry has priority
        @(negedge clk);
        artry_n = 1'b1;
        aack_n  = 1'b1;
        chk(abb_oe_o && abb_n_o && !done_o && !br_n_o, "R7 retry release",
            {abb_oe_o, abb_n_o, done_o, br_n_o}, 4'b1100);
        @(negedge clk);
        chk(!abb_oe_o && ts_n_o && !br_n_o, "R7 idle clock",
            {abb_oe_o, ts_n_o, br_n_o}, 3'b010);
        @(negedge clk);
        chk(ts_n_o, "R7 arbitration clock", ts_n_o, 1);
        @(negedge clk);
        chk(!ts_n_o, "R7 restart", ts_n_o, 0);
        ack_now("R7 retried transfer completes");
    endtask

    task automatic t_two();
        int n;
        bg_n = 1'b0;
        pulse_req();
        pulse_req();
        if (ts_n_o) wait_ts(n);
        chk(!br_n_o, "R8 request kept with second pending", br_n_o, 0);
        aack_n = 1'b0;
        @(negedge clk);
        aack_n = 1'b1;
        chk(done_o, "R6 first of two done", done_o, 1);
        wait_ts(n);
        chk(n > 0 && br_n_o, "R8 request dropped on last", {n > 0, br_n_o}, 2'b11);
        ack_now("R6 second of two done");
    endtask

    task automatic t_full();
        int n;
        int dones = 0;
        bg_n = 1'b1;
        for (int i = 0; i < MAX_PEND + 2; i++) pulse_req();
        bg_n = 1'b0;
        for (int i = 0; i < MAX_PEND + 2; i++) begin
            wait_ts(n);
            if (n < 0) break;
            aack_n = 1'b0;
            @(negedge clk);
            aack_n = 1'b1;
            if (done_o) dones++;
        end
        chk(dones == MAX_PEND, "R9 extra requests dropped", dones, MAX_PEND);
        chk(br_n_o, "R9 no request left", br_n_o, 1);
    endtask

    task automatic t_stray();
        bit bad = 1'b0;
        bg_n = 1'b0;
        @(negedge clk);
        aack_n  = 1'b0;
        artry_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (abb_oe_o || done_o || !ts_n_o || !br_n_o) bad = 1'b1;
        end
        aack_n  = 1'b1;
        artry_n = 1'b1;
        chk(!bad, "R10 stray ack and retry ignored", bad, 0);
        t_basic(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic(0);
        t_basic(1);
        t_basic(int'($urandom_range(2, 5)));
        t_busy();
        t_nogrant();
        t_retry();
        t_two();
        t_full();
        t_stray();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule